// File: doc/BRIEF.md
# Integer Compare and Carry ALU

This unit is the arithmetic corner of a small processor's integer datapath. It carries out five operations on two data-width operands: an addition, a reverse subtraction (the second operand minus the first), a signed ordering compare, an unsigned ordering compare, and a byte-pattern search. The byte-pattern search reports which byte position of the two operands is the first to hold equal values.

Both compares produce the difference `b - a`. When the operands' sign bits disagree, the top bit of that difference is replaced, so the top bit on its own tells whether `b` orders below `a`. The addition and the reverse subtraction can take their carry-in from a stored carry flag. They write their carry-out back into that flag and into a mirror copy of it, unless the keep bit asks for the flags to be left alone.

Each operation is qualified by an input strobe. The result is registered and appears one clock later with an output strobe. The flag pair updates on the same clock edge.

Top module: `cmpcarry_alu`

## Requirements
- R1: Both compare operations (op 3'b010 signed, op 3'b011 unsigned) return `b - a` in bits 30:0 of the result.
- R2: For the signed compare, result bit 31 equals bit 31 of `b` when the operand sign bits differ, and bit 31 of `b - a` otherwise. Bit 31 is therefore 1 exactly when `b` is below `a` as signed numbers.
- R3: For the unsigned compare, result bit 31 equals bit 31 of `a` when the operand sign bits differ, and bit 31 of `b - a` otherwise. Bit 31 is therefore 1 exactly when `b` is below `a` as unsigned numbers.
- R4: Add (op 3'b000) returns `a + b + cin` modulo 2^32. Here `cin` is 0 when `use_carry` is 0 and the stored carry flag when `use_carry` is 1.
- R5: Reverse subtract (op 3'b001) returns `b + ~a + cin` modulo 2^32. Here `cin` is 1 when `use_carry` is 0 and the stored carry flag when `use_carry` is 1.
- R6: A valid add or reverse subtract with `keep_carry` 0 writes the carry-out of its 32-bit sum into both `carry_flag` and `carry_copy`. With `keep_carry` 1, neither flag changes.
- R7: Byte match (op 3'b100) returns the value 1, 2, 3 or 4 for the first equal byte, searched from byte 31:24 (value 1) down to byte 7:0 (value 4). It returns 0 when no byte pair is equal.
- R8: The compares, the byte match, the unused op codes 3'b101 to 3'b111 and idle cycles leave both carry flags unchanged. The unused op codes return a result of 0.
- R9: `out_valid` is 1 exactly one cycle after a cycle with `in_valid` 1. `result` changes only after a valid operation.
- R10: While `rst_n` is low, `out_valid`, `result`, `carry_flag` and `carry_copy` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation select |
| use_carry | input | 1 | Take carry-in from the stored carry flag |
| keep_carry | input | 1 | Suppress the carry flag update |
| opa | input | 32 | Operand a |
| opb | input | 32 | Operand b |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Registered result |
| carry_flag | output | 1 | Stored carry flag |
| carry_copy | output | 1 | Mirror copy of the carry flag |

## Verification
The flag write of one add or subtract and the flag read of the next one can fall into the same clock edge. This happens when a `use_carry` operation directly follows a flag-writing one. The bench provokes it by issuing operations back to back with random `use_carry` and `keep_carry`. A reference carry value in the bench is advanced only for non-kept adds and subtracts, and each result is checked against that reference. The bench also checks that compares and byte matches interleaved in the same stream never disturb the reference value held in the flags.

// File: rtl/cmpcarry_pkg.sv
package cmpcarry_pkg;
   localparam int OP_W = 3;
   typedef enum logic [OP_W-1:0] {
      OP_ADD    = 3'b000,
      OP_RSUB   = 3'b001,
      OP_CMPS   = 3'b010,
      OP_CMPU   = 3'b011,
      OP_BMATCH = 3'b100
   } alu_op_e;
endpackage

// File: rtl/cc_addsub.sv
module cc_addsub #(
   parameter int DATA_W = 32,
   parameter int SEG_W  = 8,
   parameter bit SPLIT  = 1'b0
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout
);
   localparam int SEGS = DATA_W / SEG_W;

   if (DATA_W % SEG_W != 0) begin : g_bad_seg
      $error("cc_addsub: DATA_W must be a multiple of SEG_W");
   end

   if (SPLIT) begin : g_chain
      logic [SEGS:0] c;
      assign c[0] = cin;
      for (genvar g = 0; g < SEGS; g++) begin : g_seg
         assign {c[g+1], sum[g*SEG_W +: SEG_W]} =
            {1'b0, x[g*SEG_W +: SEG_W]} + {1'b0, y[g*SEG_W +: SEG_W]}
            + {{SEG_W{1'b0}}, c[g]};
      end
      assign cout = c[SEGS];
   end else begin : g_flat
      assign {cout, sum} = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
   end
endmodule

// File: rtl/cc_order.sv
module cc_order #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic              signed_mode,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] diff,
   output logic [DATA_W-1:0] ordered
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_w
      $error("cc_order: DATA_W must be at least 2");
   end

   logic sign_split;
   assign sign_split = a[MSB] ^ b[MSB];

   always_comb begin
      ordered = diff;
      if (sign_split) ordered[MSB] = signed_mode ? b[MSB] : a[MSB];
   end

   AST_SIGNED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en && signed_mode |-> ordered[MSB] == ($signed(b) < $signed(a))); // R2
   AST_UNSIGNED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en && !signed_mode |-> ordered[MSB] == (b < a)); // R3
   AST_LOW_BITS_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> ordered[MSB-1:0] == (b[MSB-1:0] - a[MSB-1:0])); // R1
endmodule

// File: rtl/cc_lanematch.sv
module cc_lanematch #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W,
   localparam int IDX_W = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chk_en,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [IDX_W-1:0]  idx
);
   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("cc_lanematch: DATA_W must be a multiple of LANE_W");
   end

   // hit[k]: lane k counted from the most significant end
   logic [LANES-1:0] hit;
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign hit[k] = a[DATA_W-1-k*LANE_W -: LANE_W] == b[DATA_W-1-k*LANE_W -: LANE_W];
   end

   always_comb begin
      idx = '0;
      for (int k = LANES - 1; k >= 0; k--) begin
         if (hit[k]) idx = IDX_W'(k + 1);
      end
   end

   AST_NOMATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> ((idx == '0) == (a[DATA_W-1 -: LANE_W] != b[DATA_W-1 -: LANE_W]
                   && hit == '0))); // R7
   AST_TOP_LANE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en && (a[DATA_W-1 -: LANE_W] == b[DATA_W-1 -: LANE_W]) |-> idx == IDX_W'(1)); // R7
endmodule

// File: rtl/cc_flags.sv
module cc_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic cout,
   output logic carry,
   output logic copy
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carry <= 1'b0;
         copy  <= 1'b0;
      end else if (wr_en) begin
         carry <= cout;
         copy  <= cout;
      end
   end

   AST_FLAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> carry == $past(cout) && copy == $past(cout)); // R6
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(carry) && $stable(copy)); // R8
endmodule

// File: rtl/cmpcarry_alu.sv
module cmpcarry_alu
   import cmpcarry_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int LANE_W    = 8,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op,
   input  logic              use_carry,
   input  logic              keep_carry,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              carry_flag,
   output logic              carry_copy
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int IDX_W = $clog2(LANES + 1);

   if (OP_W != 3) begin : g_bad_op
      $error("cmpcarry_alu: op width mismatch with package");
   end

   alu_op_e          op_e;
   logic [DATA_W-1:0] add_x, add_sum, ordered_w, result_d, result_q;
   logic              add_cin, add_cout, is_cmp, is_arith, flag_wr, out_valid_q;
   logic [IDX_W-1:0]  match_idx;

   assign op_e     = alu_op_e'(op);
   assign is_cmp   = (op_e == OP_CMPS) || (op_e == OP_CMPU);
   assign is_arith = (op_e == OP_ADD) || (op_e == OP_RSUB);

   // one shared adder: add uses a, subtracts and compares use ~a
   always_comb begin
      add_x   = (op_e == OP_ADD) ? opa : ~opa;
      add_cin = 1'b1;
      if (is_arith) add_cin = use_carry ? carry_flag : (op_e == OP_RSUB);
   end

   cc_addsub #(.DATA_W(DATA_W), .SEG_W(LANE_W), .SPLIT(SPLIT_ADD)) u_add (
      .x(add_x), .y(opb), .cin(add_cin), .sum(add_sum), .cout(add_cout)
   );

   cc_order #(.DATA_W(DATA_W)) u_order (
      .clk(clk), .rst_n(rst_n), .chk_en(in_valid && is_cmp),
      .signed_mode(op_e == OP_CMPS), .a(opa), .b(opb),
      .diff(add_sum), .ordered(ordered_w)
   );

   cc_lanematch #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_match (
      .clk(clk), .rst_n(rst_n), .chk_en(in_valid && op_e == OP_BMATCH),
      .a(opa), .b(opb), .idx(match_idx)
   );

   always_comb begin
      unique case (op_e)
         OP_ADD, OP_RSUB: result_d = add_sum;
         OP_CMPS, OP_CMPU: result_d = ordered_w;
         OP_BMATCH: result_d = DATA_W'(match_idx);
         default: result_d = '0;
      endcase
   end

   assign flag_wr = in_valid && is_arith && !keep_carry;

   cc_flags u_flags (
      .clk(clk), .rst_n(rst_n), .wr_en(flag_wr), .cout(add_cout),
      .carry(carry_flag), .copy(carry_copy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_q <= 1'b0;
         result_q    <= '0;
      end else begin
         out_valid_q <= in_valid;
         if (in_valid) result_q <= result_d;
      end
   end

   assign out_valid = out_valid_q;
   assign result    = result_q;

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R9
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(result)); // R9
   AST_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && keep_carry |=> $stable(carry_flag) && $stable(carry_copy)); // R6
   AST_CMP_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !is_arith |=> $stable(carry_flag)); // R8
   AST_FLAG_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      carry_flag == carry_copy); // R6
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> !out_valid && !carry_flag && result == '0); // R10
endmodule

// File: tb/cmpcarry_alu_test.sv
module cmpcarry_alu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op = 3'b000;
   logic        use_carry = 1'b0, keep_carry = 1'b0;
   logic [31:0] opa = '0, opb = '0;
   logic        out_valid, carry_flag, carry_copy;
   logic [31:0] result;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit mc     = 1'b0; // reference carry

   always #4 clk = ~clk;

   cmpcarry_alu uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .use_carry(use_carry), .keep_carry(keep_carry), .opa(opa), .opb(opb),
      .out_valid(out_valid), .result(result),
      .carry_flag(carry_flag), .carry_copy(carry_copy)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] bmatch(input logic [31:0] a, input logic [31:0] b);
      for (int i = 0; i < 4; i++)
         if (a[31-8*i -: 8] == b[31-8*i -: 8]) return 32'(i + 1);
      return 32'd0;
   endfunction

   // returns {carry_out, result}; carry_out meaningful for add/rsub
   function automatic logic [32:0] model(input logic [2:0] o, input logic [31:0] a,
                                         input logic [31:0] b, input bit uc, input bit c);
      logic [32:0] s;
      logic [31:0] d;
      case (o)
         3'b000: s = {1'b0, a} + {1'b0, b} + 33'(uc ? c : 1'b0);
         3'b001: s = {1'b0, b} + {1'b0, ~a} + 33'(uc ? c : 1'b1);
         3'b010: begin
            d = b - a;
            if ($signed(b) < $signed(a)) d[31] = 1'b1; else if (a[31] != b[31]) d[31] = 1'b0;
            s = {1'b0, d};
         end
         3'b011: begin
            d = b - a;
            if (a[31] != b[31]) d[31] = (b < a);
            s = {1'b0, d};
         end
         3'b100: s = {1'b0, bmatch(a, b)};
         default: s = '0;
      endcase
      return s;
   endfunction

   // drive at negedge, check at following negedge
   task automatic do_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input bit uc, input bit kc, input string tag);
      logic [32:0] e;
      bit arith;
      e = model(o, a, b, uc, mc);
      arith = (o == 3'b000) || (o == 3'b001);
      in_valid = 1'b1; op = o; opa = a; opb = b; use_carry = uc; keep_carry = kc;
      @(negedge clk);
      in_valid = 1'b0;
      if (arith && !kc) mc = e[32];
      check({tag, " result"}, result, e[31:0]);
      check("R9 out_valid", 32'(out_valid), 32'd1);
      check({tag, " carry (R6/R8)"}, 32'(carry_flag), 32'(mc));
      check("R6 carry copy", 32'(carry_copy), 32'(mc));
   endtask

   task automatic idle(input string tag);
      logic [31:0] held;
      held = result;
      in_valid = 1'b0; opa = $urandom; opb = $urandom; op = 3'($urandom);
      @(negedge clk);
      check({tag, " R9 no out_valid"}, 32'(out_valid), 32'd0);
      check({tag, " R9 result held"}, result, held);
      check({tag, " R8 carry held"}, 32'(carry_flag), 32'(mc));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R10 out_valid", 32'(out_valid), 32'd0);
      check("R10 result", result, 32'd0);
      check("R10 carry", 32'(carry_flag), 32'd0);
      check("R10 copy", 32'(carry_copy), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      do_op(3'b010, 32'h0000_0005, 32'h0000_0005, 0, 0, "R1 cmps equal");
      do_op(3'b010, 32'h0000_0001, 32'hFFFF_FFFF, 0, 0, "R2 cmps b=-1 a=1");
      do_op(3'b010, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, "R2 cmps sign split");
      do_op(3'b011, 32'h0000_0001, 32'hFFFF_FFFF, 0, 0, "R3 cmpu b big");
      do_op(3'b011, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, "R3 cmpu sign split");
      do_op(3'b000, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, "R4 add wrap");
      do_op(3'b000, 32'h0000_0010, 32'h0000_0020, 1, 1, "R4 add carry-in kept");
      do_op(3'b001, 32'h0000_0003, 32'h0000_0001, 0, 0, "R5 rsub borrow");
      do_op(3'b001, 32'h0000_0001, 32'h0000_0003, 1, 0, "R5 rsub carry-in");
      do_op(3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, "R6 add keep");
      do_op(3'b100, 32'h1122_3344, 32'h1199_9999, 0, 0, "R7 match byte1");
      do_op(3'b100, 32'h1122_3344, 32'h0022_0044, 0, 0, "R7 match byte2");
      do_op(3'b100, 32'h1122_3344, 32'h0000_3300, 0, 0, "R7 match byte3");
      do_op(3'b100, 32'h1122_3344, 32'h0000_0044, 0, 0, "R7 match byte4");
      do_op(3'b100, 32'h1122_3344, 32'h2233_4455, 0, 0, "R7 no match");
      do_op(3'b110, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, "R8 unused op");
      idle("idle");

      // constrained random, back-to-back and with gaps
      for (int n = 0; n < 600; n++) begin
         logic [31:0] a, b;
         logic [2:0]  o;
         o = 3'($urandom_range(0, 5));
         a = $urandom; b = $urandom;
         if ($urandom_range(0, 3) == 0) b = a ^ (32'hFF << (8 * $urandom_range(0, 3)));
         if ($urandom_range(0, 7) == 0) a = {$urandom_range(0, 1) ? 1'b1 : 1'b0, 31'h0};
         do_op(o, a, b, 1'($urandom), 1'($urandom_range(0, 3) == 0),
               o == 3'b000 ? "R4 rnd" : o == 3'b001 ? "R5 rnd" :
               o == 3'b010 ? "R2 rnd" : o == 3'b011 ? "R3 rnd" :
               o == 3'b100 ? "R7 rnd" : "R8 rnd");
         if ($urandom_range(0, 5) == 0) idle("rnd idle");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule